// File: doc/BRIEF.md
# Local Bus Banked Memory Window

This block sits behind a 32-bit local bus slave port and steers each bus access to one of several memory banks. A single 32-bit control register, reached through the bus itself, holds a 3-bit bank code and a page field. The bank code picks four external SRAM banks, two internal block RAMs (one general purpose, one reserved for DMA capture) or one of two unmapped codes. The page field supplies the upper SRAM address bits above the bus word offset. One further control bit drives an interrupt output pin.

The top address bit of the bus word address separates control register accesses (bit set) from memory window accesses (bit cleared). Every access is acknowledged by a one-cycle pulse on the acknowledge output. Reads are acknowledged only when data from the selected memory is present, so the host must wait for the acknowledge before issuing the next strobe. Behavioural memory models with fixed read latencies stand in for the SRAM banks and the block RAMs.

Top module: `lbw_top`

## Requirements
- R1: After synchronous active-low reset the control register reads as zero, so the bank code is 0, the page is 0 and `irq_out` is 0. No acknowledge is pending.
- R2: With `lb_addr[WIN_AW]` = 1 the access targets the control register. A write updates only the byte lanes whose `lb_be` bit is set (bit k covers data bits 8k+7:8k). A read returns the full stored 32-bit value. Both are acknowledged one cycle after the strobe edge.
- R3: Control bits 2:0 choose the bank for window accesses (`lb_addr[WIN_AW]` = 0). Codes 0 to 3 select SRAM banks 0 to 3, code 6 selects the general block RAM and code 7 selects the capture block RAM. Read data comes from the selected bank only, and each bank keeps its own contents.
- R4: For SRAM banks the word address is the page field, taken from control bits 4 upward (PAGE_W bits, at most 4), concatenated above `lb_addr[WIN_AW-1:0]`. Block RAMs use the bus offset only and ignore the page.
- R5: A read from an SRAM bank is acknowledged two cycles after the strobe edge. Reads from a block RAM, the control register or an unmapped code are acknowledged one cycle after it. Every write is acknowledged one cycle after it.
- R6: `lb_ack` is a single-cycle pulse for each access.
- R7: In every mapped bank a write changes only the byte lanes enabled by `lb_be`, using the same lane mapping as R2.
- R8: Codes 4 and 5 are unmapped. Reads return zero and are still acknowledged. Writes change no bank.
- R9: `irq_out` follows control register bit 24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lb_addr | input | WIN_AW+1 | Word address; top bit selects the control register |
| lb_wdata | input | 32 | Write data |
| lb_be | input | 4 | Byte lane enables for writes |
| lb_wr | input | 1 | Write strobe, one cycle |
| lb_rd | input | 1 | Read strobe, one cycle |
| lb_rdata | output | 32 | Read data, valid while `lb_ack` is high on a read |
| lb_ack | output | 1 | One-cycle acknowledge |
| irq_out | output | 1 | Interrupt pin driven by control bit 24 |

## Verification
The bench builds the block with WIN_AW = 2 and PAGE_W = 2. That makes each SRAM bank 16 words and each block RAM 4 words, so one sweep can write and read back every word of every bank code under every page. With a bank this small, any aliasing between pages, between banks or through the unmapped codes shows up as a data mismatch. Every access in the sweep also has its acknowledge latency and pulse width measured. Byte-lane merges are then run on each mapped bank and on the control register.

// File: rtl/lbw_pkg.sv
// Shared constants for the banked memory window.
// Assumes a 32-bit bus and the fixed bank code assignment listed in the brief.
package lbw_pkg;
    localparam int DATA_W   = 32;
    localparam int BE_W     = DATA_W / 8;
    localparam int N_SRAM   = 4;
    localparam int N_BRAM   = 2;
    localparam int N_SLOT   = N_SRAM + N_BRAM;
    localparam int SRAM_LAT = 2;
    localparam int BRAM_LAT = 1;
    localparam int IRQ_BIT  = 24;
    localparam int PAGE_LSB = 4;

    typedef enum logic [2:0] {
        BK_SRAM0 = 3'd0,
        BK_SRAM1 = 3'd1,
        BK_SRAM2 = 3'd2,
        BK_SRAM3 = 3'd3,
        BK_HOLE0 = 3'd4,
        BK_HOLE1 = 3'd5,
        BK_BRAM  = 3'd6,
        BK_CAPT  = 3'd7
    } bank_e;
endpackage

// File: rtl/lbw_ctrl_reg.sv
// Control register with byte-lane writes.
// Assumes wr_en is a one-cycle pulse qualified by the register address bit.
module lbw_ctrl_reg
    import lbw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q
);
    // Store enabled byte lanes; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < BE_W; b++) begin
                if (be[b]) ctrl_q[8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end
endmodule

// File: rtl/lbw_bank_decode.sv
// Turns the bank code into one enable per memory slot.
// Slots 0..N_SRAM-1 are SRAM banks, then the general and capture block RAMs.
module lbw_bank_decode
    import lbw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_acc,
    input  logic [2:0]        code,
    output logic [N_SLOT-1:0] slot_en,
    output logic              unmapped
);
    // Decode the code into slot enables, gated by a window access.
    always_comb begin
        slot_en  = '0;
        unmapped = 1'b0;
        unique case (bank_e'(code))
            BK_SRAM0, BK_SRAM1,
            BK_SRAM2, BK_SRAM3: slot_en[code[1:0]]   = win_acc;
            BK_BRAM:            slot_en[N_SRAM]     = win_acc;
            BK_CAPT:            slot_en[N_SRAM + 1] = win_acc;
            default:            unmapped            = win_acc;
        endcase
    end

    // R3: at most one memory slot is enabled at a time
    a_r3_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_en));
    // R8: unmapped codes enable no slot
    a_r8_hole_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (slot_en == '0));
endmodule

// File: rtl/lbw_mem_model.sv
// Behavioural single-port memory with byte-lane writes and a fixed read latency.
// Assumes LAT is 1 or 2. Memory contents are not reset; pipeline registers are.
module lbw_mem_model
    import lbw_pkg::*;
#(
    parameter int AW  = 4,
    parameter int LAT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr,
    input  logic              rd,
    input  logic [BE_W-1:0]   be,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] d1;
    logic              v1;

    // Write the enabled byte lanes.
    always_ff @(posedge clk) begin
        for (int b = 0; b < BE_W; b++) begin
            if (en && wr && be[b]) mem[addr][8*b +: 8] <= wdata[8*b +: 8];
        end
    end

    // First read stage: array lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0;
            d1 <= '0;
        end else begin
            v1 <= en && rd;
            if (en && rd) d1 <= mem[addr];
        end
    end

    generate
        if (LAT == 2) begin : g_two
            logic [DATA_W-1:0] d2;
            logic              v2;
            // Second read stage: models the external pipeline register.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v2 <= 1'b0;
                    d2 <= '0;
                end else begin
                    v2 <= v1;
                    d2 <= d1;
                end
            end
            assign rdata  = d2;
            assign rvalid = v2;
        end else begin : g_one
            assign rdata  = d1;
            assign rvalid = v1;
        end
    endgenerate
endmodule

// File: rtl/lbw_top.sv
// Local bus banked memory window.
// Assumes one outstanding access: the host waits for lb_ack before the next strobe,
// and the control register is not rewritten while a read is in flight.
module lbw_top
    import lbw_pkg::*;
#(
    parameter int WIN_AW = 4,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIN_AW:0]   lb_addr,
    input  logic [DATA_W-1:0] lb_wdata,
    input  logic [BE_W-1:0]   lb_be,
    input  logic              lb_wr,
    input  logic              lb_rd,
    output logic [DATA_W-1:0] lb_rdata,
    output logic              lb_ack,
    output logic              irq_out
);
    localparam int SRAM_AW = PAGE_W + WIN_AW;

    logic                reg_hit, win_acc, unmapped;
    logic [DATA_W-1:0]   ctrl_q;
    logic [2:0]          code;
    logic [PAGE_W-1:0]   page;
    logic [N_SLOT-1:0]   slot_en, slot_v;
    logic [DATA_W-1:0]   slot_d [N_SLOT];
    logic [SRAM_AW-1:0]  sram_addr;
    logic                wr_ack_q, reg_rd_q, hole_rd_q;

    assign reg_hit   = lb_addr[WIN_AW];
    assign win_acc   = (lb_wr || lb_rd) && !reg_hit;
    assign code      = ctrl_q[2:0];
    assign page      = ctrl_q[PAGE_LSB +: PAGE_W];
    assign irq_out   = ctrl_q[IRQ_BIT];
    assign sram_addr = {page, lb_addr[WIN_AW-1:0]};

    lbw_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(lb_wr && reg_hit),
        .be(lb_be), .wdata(lb_wdata), .ctrl_q(ctrl_q)
    );

    lbw_bank_decode u_dec (
        .clk(clk), .rst_n(rst_n), .win_acc(win_acc), .code(code),
        .slot_en(slot_en), .unmapped(unmapped)
    );

    generate
        for (genvar i = 0; i < N_SRAM; i++) begin : g_sram
            lbw_mem_model #(.AW(SRAM_AW), .LAT(SRAM_LAT)) u_mem (
                .clk(clk), .rst_n(rst_n), .en(slot_en[i]), .wr(lb_wr), .rd(lb_rd),
                .be(lb_be), .addr(sram_addr), .wdata(lb_wdata),
                .rdata(slot_d[i]), .rvalid(slot_v[i])
            );
        end
        for (genvar j = 0; j < N_BRAM; j++) begin : g_bram
            lbw_mem_model #(.AW(WIN_AW), .LAT(BRAM_LAT)) u_mem (
                .clk(clk), .rst_n(rst_n), .en(slot_en[N_SRAM + j]), .wr(lb_wr),
                .rd(lb_rd), .be(lb_be), .addr(lb_addr[WIN_AW-1:0]),
                .wdata(lb_wdata), .rdata(slot_d[N_SRAM + j]),
                .rvalid(slot_v[N_SRAM + j])
            );
        end
    endgenerate

    // Track accesses that are acknowledged one cycle later without a memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ack_q  <= 1'b0;
            reg_rd_q  <= 1'b0;
            hole_rd_q <= 1'b0;
        end else begin
            wr_ack_q  <= lb_wr;
            reg_rd_q  <= lb_rd && reg_hit;
            hole_rd_q <= lb_rd && unmapped;
        end
    end

    assign lb_ack = wr_ack_q || reg_rd_q || hole_rd_q || (|slot_v);

    // Return data: register readback, else a mux keyed on the bank code.
    always_comb begin
        if (reg_rd_q) begin
            lb_rdata = ctrl_q;
        end else begin
            unique case (bank_e'(code))
                BK_SRAM0, BK_SRAM1,
                BK_SRAM2, BK_SRAM3: lb_rdata = slot_d[code[1:0]];
                BK_BRAM:            lb_rdata = slot_d[N_SRAM];
                BK_CAPT:            lb_rdata = slot_d[N_SRAM + 1];
                default:            lb_rdata = '0;
            endcase
        end
    end

    // R6: acknowledge lasts one cycle
    a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        lb_ack |=> !lb_ack);
    // R5: SRAM read acknowledged on the second cycle, not the first
    a_r5_sram_lat: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_rd && !reg_hit && !code[2]) |=> !lb_ack ##1 lb_ack);
    // R5: block RAM read acknowledged on the next cycle
    a_r5_bram_lat: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_rd && !reg_hit && code[2] && code[1]) |=> lb_ack);
    // R8: unmapped read is acknowledged with zero data
    a_r8_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_rd && !reg_hit && code[2] && !code[1]) |=> (lb_ack && lb_rdata == '0));
    // R9: writing byte lane 3 of the register sets the interrupt pin
    a_r9_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_wr && reg_hit && lb_be[3]) |=> (irq_out == $past(lb_wdata[IRQ_BIT])));
endmodule

// File: tb/sim_lbw_top.sv
`timescale 1ns/1ps
module sim_lbw_top;
    localparam int WA = 2;
    localparam int PW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [WA:0] lb_addr = '0;
    logic [31:0] lb_wdata = '0;
    logic [3:0]  lb_be = '0;
    logic        lb_wr = 1'b0;
    logic        lb_rd = 1'b0;
    logic [31:0] lb_rdata;
    logic        lb_ack;
    logic        irq_out;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [31:0] sh [8][16];

    localparam logic [WA:0] REG_A = 3'b100;

    always #2.5 clk = ~clk;

    lbw_top #(.WIN_AW(WA), .PAGE_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .lb_addr(lb_addr), .lb_wdata(lb_wdata),
        .lb_be(lb_be), .lb_wr(lb_wr), .lb_rd(lb_rd), .lb_rdata(lb_rdata),
        .lb_ack(lb_ack), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus access; returns data, latency in cycles and whether ack was a pulse.
    task automatic op(input logic w, input logic [WA:0] a, input logic [31:0] d,
                      input logic [3:0] be, output logic [31:0] q, output int lat,
                      output logic pulse);
        @(negedge clk);
        lb_addr = a; lb_wdata = d; lb_be = be; lb_wr = w; lb_rd = !w;
        @(posedge clk);
        #1 lb_wr = 1'b0; lb_rd = 1'b0;
        lat = 0; q = '0;
        while (lat < 6) begin
            @(negedge clk);
            lat++;
            if (lb_ack) begin q = lb_rdata; break; end
        end
        @(negedge clk);
        pulse = !lb_ack;
    endtask

    task automatic set_ctrl(input int code, input int page, input logic irq);
        logic [31:0] q; int lat; logic p;
        op(1'b1, REG_A, (32'(irq) << 24) | (32'(page) << 4) | 32'(code), 4'hF, q, lat, p);
    endtask

    initial begin
        logic [31:0] q; int lat; logic p; logic [31:0] e;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after reset", 32'(irq_out), 32'd0);
        chk("R1 ack after reset", 32'(lb_ack), 32'd0);
        op(1'b0, REG_A, '0, 4'h0, q, lat, p);
        chk("R1 ctrl after reset", q, 32'd0);
        chk("R2 reg read latency", 32'(lat), 32'd1);

        // R2 register byte lanes
        op(1'b1, REG_A, 32'hFFFF_FFFF, 4'b0010, q, lat, p);
        chk("R2 reg write latency", 32'(lat), 32'd1);
        op(1'b0, REG_A, '0, 4'h0, q, lat, p);
        chk("R2 lane1 only", q, 32'h0000_FF00);
        op(1'b1, REG_A, 32'h1234_5678, 4'b0101, q, lat, p);
        op(1'b0, REG_A, '0, 4'h0, q, lat, p);
        chk("R2 lanes 0 and 2", q, 32'h0034_FF78);

        // R9 interrupt pin
        op(1'b1, REG_A, 32'h0100_0000, 4'b1000, q, lat, p);
        chk("R9 irq set", 32'(irq_out), 32'd1);
        op(1'b1, REG_A, 32'h0000_0000, 4'b1000, q, lat, p);
        chk("R9 irq clear", 32'(irq_out), 32'd0);

        // R3 R4 R8 full write sweep
        for (int c = 0; c < 8; c++) begin
            for (int pg = 0; pg < 4; pg++) begin
                set_ctrl(c, pg, 1'b0);
                for (int o = 0; o < 4; o++) begin
                    e = 32'hA000_0000 | (32'(c) << 16) | (32'(pg) << 8) | 32'(o);
                    op(1'b1, 3'(o), e, 4'hF, q, lat, p);
                    chk("R5 write latency", 32'(lat), 32'd1);
                    if (c < 4) sh[c][pg*4 + o] = e;
                    else if (c >= 6) sh[c][o] = e;
                end
            end
        end
        // Read sweep
        for (int c = 0; c < 8; c++) begin
            for (int pg = 0; pg < 4; pg++) begin
                set_ctrl(c, pg, 1'b0);
                for (int o = 0; o < 4; o++) begin
                    op(1'b0, 3'(o), '0, 4'h0, q, lat, p);
                    if (c < 4) begin
                        chk("R3/R4 sram data", q, sh[c][pg*4 + o]);
                        chk("R5 sram read latency", 32'(lat), 32'd2);
                    end else if (c >= 6) begin
                        chk("R3/R4 bram data", q, sh[c][o]);
                        chk("R5 bram read latency", 32'(lat), 32'd1);
                    end else begin
                        chk("R8 hole reads zero", q, 32'd0);
                        chk("R8 hole acked", 32'(lat), 32'd1);
                    end
                    chk("R6 ack pulse", 32'(p), 32'd1);
                end
            end
        end

        // R7 byte lanes in every mapped bank
        for (int c = 0; c < 8; c++) begin
            if (c == 4 || c == 5) continue;
            set_ctrl(c, 1, 1'b0);
            op(1'b1, 3'd2, 32'h1122_3344, 4'hF, q, lat, p);
            op(1'b1, 3'd2, 32'hAABB_CCDD, 4'b1010, q, lat, p);
            op(1'b0, 3'd2, '0, 4'h0, q, lat, p);
            chk("R7 lanes 1 and 3", q, 32'hAA22_CC44);
            op(1'b1, 3'd2, 32'h5566_7788, 4'b0101, q, lat, p);
            op(1'b0, 3'd2, '0, 4'h0, q, lat, p);
            chk("R7 lanes 0 and 2", q, 32'hAA66_CC88);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule